// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Bank

This block collects up to 32 active-low interrupt lines into one bank. It picks the most urgent pending line that software has unmasked and signals it on one of two active-low processor outputs: a normal request (`irqN`) or a fast request (`fiqN`). Each line has its own configuration word. That word chooses between edge and level sensing, sets a 5-bit urgency value, and, in bank 0 only, steers the line to the fast output. Software reads which line won, then releases the output by writing acknowledge bits. A global gate holds both outputs quiet until software opens it.

Larger systems build from several banks. A line's global number selects the bank with its upper bits (number >> 5) and the line within the bank with its low five bits. A second bank is cascaded by wiring its `irqN` into one input of bank 0. That input is set to level sensing and must be unmasked for the second bank's requests to reach the processor. The parameter `BANK_ID` tells the bank its position in the chain.

Top module: `prio_irq_bank`

## Requirements
- R1: Register 0x04 holds one mask bit per line. A 1 blocks the line and a 0 lets it through. Every bit resets to 1.
- R2: The configuration word of line n is at byte address 0x20 + 4*n. Bit 0 steers the line to `fiqN`, bit 1 selects level (1) or edge (0) sensing, and bits 6:2 hold the urgency value. All other bits read 0.
- R3: When `BANK_ID` is not 0, the steering bit always reads 0 and `fiqN` never asserts.
- R4: Among candidates for the same output, the lowest urgency value wins, and on a tie the lower line number wins. The source register (0x08 for `irqN`, 0x0C for `fiqN`) holds the line number in bits 4:0 and its urgency value in bits 12:8.
- R5: An edge-sensed line latches a falling edge and stays pending after the input returns high. A level-sensed line is pending only while its input is low and is never latched. Register 0x00 reads the pending state of every line, whether or not it is masked.
- R6: Writing register 0x00 clears each latched edge whose written bit is 0 and leaves the bits written 1 unchanged.
- R7: Once an output asserts, its source register and the output stay fixed until the acknowledge bit is written. The acknowledge bits are in register 0x10: bit 0 releases `irqN`, bit 1 releases `fiqN`, and 0x3 releases both. Release clears the winner's latched edge, and a new choice can be made from the following cycle.
- R8: Bit 0 of register 0x14 is a global gate. It resets to 1, and while it is 1 both outputs stay high. Writing 0 opens the gate and lets requests through.
- R9: A second bank whose `irqN` drives a level-sensed line of bank 0 reaches bank 0's `irqN` only when that line is unmasked in bank 0.
- R10: After reset both outputs are high and no line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcN | input | LINES | Active-low interrupt inputs |
| regAddr | input | ADDR_W | Register byte address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| irqN | output | 1 | Active-low normal interrupt request |
| fiqN | output | 1 | Active-low fast interrupt request |

## Verification
The selection logic is tried with several patterns of simultaneous candidates:
- A single line on its own shows that the source register is captured.
- Three lines, two of them with equal urgency, separate the urgency order from the line-number tie break once the best line is retired.
- A more urgent line that arrives while another is held shows that the held choice is frozen rather than re-evaluated.

Further patterns isolate the other rules:
- A one-cycle pulse on an edge line and a held then released level line tell latching apart from direct sampling.
- A masked pending line, and the same line with the global gate closed, separate the per-line mask from the global gate.
- Fast-steered lines in bank 0 and in bank 1 separate the two outputs and show that bank 1 suppresses the fast output.
- The two-bank chain, with the cascade line first masked and then unmasked, shows that the second bank's requests pass through bank 0.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  // register byte offsets
  localparam int OFF_PEND   = 'h00;
  localparam int OFF_MASK   = 'h04;
  localparam int OFF_IRQSRC = 'h08;
  localparam int OFF_FIQSRC = 'h0C;
  localparam int OFF_ACK    = 'h10;
  localparam int OFF_GATE   = 'h14;
  localparam int OFF_CFG    = 'h20;

  // strobes from control to datapath
  typedef struct packed {
    logic capIrq;
    logic capFiq;
    logic relIrq;
    logic relFiq;
  } bank_stb_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int LINES  = 32,
  parameter int PRIO_W = 5,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0]        cand,
  input  logic [LINES*PRIO_W-1:0] prioFlat,
  output logic                    any,
  output logic [IDX_W-1:0]        idx,
  output logic [PRIO_W-1:0]       prio
);
  // strict less-than keeps the lowest index on a tie
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    prio = '1;
    for (int i = 0; i < LINES; i++) begin
      if (cand[i] && (!any || prioFlat[i*PRIO_W +: PRIO_W] < prio)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        prio = prioFlat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_bank_ctl.sv
module irq_bank_ctl
  import irq_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      gEn,
  input  logic      irqAny,
  input  logic      fiqAny,
  input  logic      ackIrq,
  input  logic      ackFiq,
  output bank_stb_t stb,
  output logic      irqN,
  output logic      fiqN
);
  logic irqHold, fiqHold;

  always_comb begin
    stb.capIrq = gEn && !irqHold && irqAny;
    stb.capFiq = gEn && !fiqHold && fiqAny;
    stb.relIrq = irqHold && ackIrq;
    stb.relFiq = fiqHold && ackFiq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqHold <= 1'b0;
      fiqHold <= 1'b0;
    end else begin
      irqHold <= gEn && (irqHold ? !ackIrq : irqAny);
      fiqHold <= gEn && (fiqHold ? !ackFiq : fiqAny);
    end
  end

  assign irqN = ~irqHold;
  assign fiqN = ~fiqHold;
endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int LINES   = 32,
  parameter int PRIO_W  = 5,
  parameter int BANK_ID = 0,
  parameter int ADDR_W  = 8,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  srcN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  bank_stb_t         stb,
  output logic              irqAny,
  output logic              fiqAny,
  output logic              gEn,
  output logic              ackIrq,
  output logic              ackFiq,
  output logic [LINES-1:0]  maskReg,
  output logic [IDX_W-1:0]  irqLine
);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_IRQSRC = ADDR_W'(OFF_IRQSRC);
  localparam logic [ADDR_W-1:0] A_FIQSRC = ADDR_W'(OFF_FIQSRC);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_GATE   = ADDR_W'(OFF_GATE);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);

  logic [LINES-1:0]        sIn, sInPrev, latched, pending;
  logic [LINES-1:0]        fiqSel, trigSel, fallVec, clrVec, keepVec;
  logic [LINES*PRIO_W-1:0] prioFlat;
  logic                    gateReg;
  logic [PRIO_W-1:0]       irqPrio, fiqPrio, irqBestP, fiqBestP;
  logic [IDX_W-1:0]        fiqLine, irqBest, fiqBest;
  logic [ADDR_W-1:0]       cfgOff;
  logic                    cfgHit;
  logic [IDX_W-1:0]        cfgIdx;

  // configuration word decode
  assign cfgOff = regAddr - A_CFG;
  assign cfgHit = (regAddr >= A_CFG) && (cfgOff[1:0] == 2'b00) &&
                  ((cfgOff >> 2) < ADDR_W'(LINES));
  assign cfgIdx = cfgOff[IDX_W+1:2];

  assign ackIrq = regWe && (regAddr == A_ACK) && regWdata[0];
  assign ackFiq = regWe && (regAddr == A_ACK) && regWdata[1];
  assign gEn    = ~gateReg;

  // per-line configuration
  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic              cfgWr;
    logic              trigR;
    logic [PRIO_W-1:0] prioR;
    assign cfgWr = regWe && cfgHit && (cfgIdx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        trigR <= 1'b0;
        prioR <= '0;
      end else if (cfgWr) begin
        trigR <= regWdata[1];
        prioR <= regWdata[PRIO_W+1:2];
      end
    end
    assign trigSel[g] = trigR;
    assign prioFlat[g*PRIO_W +: PRIO_W] = prioR;
    if (BANK_ID == 0) begin : gFiq
      logic fiqR;
      always_ff @(posedge clk) begin
        if (!rstN)      fiqR <= 1'b0;
        else if (cfgWr) fiqR <= regWdata[0];
      end
      assign fiqSel[g] = fiqR;
    end else begin : gNoFiq
      assign fiqSel[g] = 1'b0;
    end
  end

  // input sampling, edge latching, pending vector
  assign fallVec = sInPrev & ~sIn & ~trigSel;
  assign keepVec = (regWe && regAddr == A_PEND) ? regWdata[LINES-1:0] : '1;
  assign clrVec  = (stb.relIrq ? (LINES'(1) << irqLine) : '0) |
                   (stb.relFiq ? (LINES'(1) << fiqLine) : '0);
  assign pending = (trigSel & ~sIn) | (~trigSel & latched);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sIn     <= '1;
      sInPrev <= '1;
      latched <= '0;
      maskReg <= '1;
      gateReg <= 1'b1;
    end else begin
      sIn     <= srcN;
      sInPrev <= sIn;
      latched <= (latched & keepVec & ~clrVec) | fallVec;
      if (regWe && regAddr == A_MASK) maskReg <= regWdata[LINES-1:0];
      if (regWe && regAddr == A_GATE) gateReg <= regWdata[0];
    end
  end

  // one selector per output
  irq_pick #(.LINES(LINES), .PRIO_W(PRIO_W)) uPickIrq (
    .cand(pending & ~maskReg & ~fiqSel), .prioFlat(prioFlat),
    .any(irqAny), .idx(irqBest), .prio(irqBestP));
  irq_pick #(.LINES(LINES), .PRIO_W(PRIO_W)) uPickFiq (
    .cand(pending & ~maskReg & fiqSel), .prioFlat(prioFlat),
    .any(fiqAny), .idx(fiqBest), .prio(fiqBestP));

  // captured winners
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqLine <= '0;
      irqPrio <= '0;
      fiqLine <= '0;
      fiqPrio <= '0;
    end else begin
      if (stb.capIrq) begin
        irqLine <= irqBest;
        irqPrio <= irqBestP;
      end
      if (stb.capFiq) begin
        fiqLine <= fiqBest;
        fiqPrio <= fiqBestP;
      end
    end
  end

  // read mux
  always_comb begin
    regRdata = '0;
    if (cfgHit) begin
      regRdata = 32'({prioFlat[cfgIdx*PRIO_W +: PRIO_W], trigSel[cfgIdx], fiqSel[cfgIdx]});
    end else begin
      case (regAddr)
        A_PEND:   regRdata = 32'(pending);
        A_MASK:   regRdata = 32'(maskReg);
        A_IRQSRC: regRdata = (32'(irqPrio) << 8) | 32'(irqLine);
        A_FIQSRC: regRdata = (32'(fiqPrio) << 8) | 32'(fiqLine);
        A_GATE:   regRdata = 32'(gateReg);
        default:  regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_bank.sv
module prio_irq_bank
  import irq_bank_pkg::*;
#(
  parameter int LINES   = 32,
  parameter int PRIO_W  = 5,
  parameter int BANK_ID = 0,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  srcN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irqN,
  output logic              fiqN
);
  localparam int IDX_W = $clog2(LINES);

  bank_stb_t        stb;
  logic             irqAny, fiqAny, gEn, ackIrq, ackFiq;
  logic [LINES-1:0] maskReg;
  logic [IDX_W-1:0] irqLine;

  irq_bank_dp #(.LINES(LINES), .PRIO_W(PRIO_W), .BANK_ID(BANK_ID), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .srcN(srcN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .stb(stb), .irqAny(irqAny),
    .fiqAny(fiqAny), .gEn(gEn), .ackIrq(ackIrq), .ackFiq(ackFiq),
    .maskReg(maskReg), .irqLine(irqLine));

  irq_bank_ctl uCtl (
    .clk(clk), .rstN(rstN), .gEn(gEn), .irqAny(irqAny), .fiqAny(fiqAny),
    .ackIrq(ackIrq), .ackFiq(ackFiq), .stb(stb), .irqN(irqN), .fiqN(fiqN));
endmodule

// File: rtl/prio_irq_bank_chk.sv
module prio_irq_bank_chk #(
  parameter int LINES   = 32,
  parameter int BANK_ID = 0,
  localparam int IDX_W  = $clog2(LINES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             irqN,
  input logic             fiqN,
  input logic             gEn,
  input logic             ackIrq,
  input logic [LINES-1:0] maskReg,
  input logic [IDX_W-1:0] irqLine
);
  logic [LINES-1:0] maskPrev;
  always_ff @(posedge clk) begin
    if (!rstN) maskPrev <= '1;
    else       maskPrev <= maskReg;
  end

  // a newly asserted request names a line that was unmasked when chosen
  assert_mask_honored_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> !maskPrev[irqLine]);

  // held request and its source do not move until acknowledged
  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!irqN && !ackIrq && gEn) |=> (!irqN && $stable(irqLine)));

  assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!irqN && ackIrq) |=> irqN);

  assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rstN)
    !gEn |=> (irqN && fiqN));

  if (BANK_ID != 0) begin : gNoFiqChk
    assert_no_fast_R3: assert property (@(posedge clk) disable iff (!rstN) fiqN);
  end
endmodule

bind prio_irq_bank prio_irq_bank_chk #(.LINES(LINES), .BANK_ID(BANK_ID)) uChk (
  .clk(clk), .rstN(rstN), .irqN(irqN), .fiqN(fiqN), .gEn(gEn),
  .ackIrq(ackIrq), .maskReg(maskReg), .irqLine(irqLine));

// File: tb/sim_prio_irq_bank.sv
`timescale 1ns/100ps
module sim_prio_irq_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] src0 = '1, src1 = '1;
  logic [7:0]  addr0 = '0, addr1 = '0;
  logic        we0 = 1'b0, we1 = 1'b0;
  logic [31:0] wd0 = '0, wd1 = '0, rd0, rd1;
  logic        irqN0, fiqN0, irqN1, fiqN1;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  // bank 0 line 0 carries bank 1's request
  prio_irq_bank #(.BANK_ID(0)) u0 (
    .clk(clk), .rstN(rstN), .srcN({src0[31:1], irqN1}), .regAddr(addr0),
    .regWe(we0), .regWdata(wd0), .regRdata(rd0), .irqN(irqN0), .fiqN(fiqN0));
  prio_irq_bank #(.BANK_ID(1)) u1 (
    .clk(clk), .rstN(rstN), .srcN(src1), .regAddr(addr1),
    .regWe(we1), .regWdata(wd1), .regRdata(rd1), .irqN(irqN1), .fiqN(fiqN1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int b, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    if (b == 0) begin addr0 = a; wd0 = d; we0 = 1'b1; end
    else        begin addr1 = a; wd1 = d; we1 = 1'b1; end
    @(negedge clk);
    we0 = 1'b0;
    we1 = 1'b0;
  endtask

  task automatic rd(input int b, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    if (b == 0) addr0 = a; else addr1 = a;
    #1;
    d = (b == 0) ? rd0 : rd1;
  endtask

  function automatic logic [31:0] cfg(input int fiq, input int lvl, input int pr);
    return 32'((pr << 2) | (lvl << 1) | fiq);
  endfunction

  task automatic cleanup(input int b);
    if (b == 0) src0 = '1; else src1 = '1;
    wr(b, 8'h04, '1);
    wr(b, 8'h10, 32'h3);
    wr(b, 8'h00, 32'h0);
    idle(3);
  endtask

  task automatic test_reset;
    logic [31:0] v;
    chk("R10 irqN after reset", 32'(irqN0), 1);
    chk("R10 fiqN after reset", 32'(fiqN0), 1);
    rd(0, 8'h04, v); chk("R1 mask reset all ones", v, 32'hFFFF_FFFF);
    rd(0, 8'h14, v); chk("R8 gate reset closed", v, 1);
    rd(0, 8'h00, v); chk("R10 nothing pending", v, 0);
  endtask

  task automatic test_gate;
    logic [31:0] v;
    wr(0, 8'h20 + 4*5, cfg(0, 1, 3));
    src0[5] = 1'b0;
    wr(0, 8'h04, ~(32'h1 << 5));
    idle(4);
    chk("R8 closed gate holds irqN high", 32'(irqN0), 1);
    wr(0, 8'h14, 32'h0);
    idle(4);
    chk("R8 open gate delivers", 32'(irqN0), 0);
    rd(0, 8'h08, v); chk("R4 source line5 prio3", v, 32'h305);
    cleanup(0);
  endtask

  task automatic test_mask;
    src0[5] = 1'b0;
    idle(4);
    chk("R1 masked line ignored", 32'(irqN0), 1);
    wr(0, 8'h04, ~(32'h1 << 5));
    idle(4);
    chk("R1 unmasked line delivered", 32'(irqN0), 0);
    wr(0, 8'h04, '1);
    idle(3);
    chk("R7 held through re-mask", 32'(irqN0), 0);
    wr(0, 8'h10, 32'h1);
    idle(3);
    chk("R1 masked after ack stays quiet", 32'(irqN0), 1);
    cleanup(0);
  endtask

  task automatic test_prio;
    logic [31:0] v;
    wr(0, 8'h20 + 4*7,  cfg(0, 1, 9));
    wr(0, 8'h20 + 4*3,  cfg(0, 1, 9));
    wr(0, 8'h20 + 4*12, cfg(0, 1, 2));
    src0[7] = 1'b0; src0[3] = 1'b0; src0[12] = 1'b0;
    idle(3);
    wr(0, 8'h04, ~((32'h1 << 7) | (32'h1 << 3) | (32'h1 << 12)));
    idle(4);
    rd(0, 8'h08, v); chk("R4 lowest value wins", v, 32'h20C);
    src0[12] = 1'b1;
    idle(2);
    wr(0, 8'h10, 32'h1);
    idle(4);
    rd(0, 8'h08, v); chk("R4 tie goes to lower line", v, 32'h903);
    chk("R4 next winner asserted", 32'(irqN0), 0);
    cleanup(0);
  endtask

  task automatic test_frozen;
    logic [31:0] v;
    wr(0, 8'h20 + 4*9, cfg(0, 1, 5));
    wr(0, 8'h20 + 4*2, cfg(0, 1, 0));
    src0[9] = 1'b0;
    wr(0, 8'h04, ~((32'h1 << 9) | (32'h1 << 2)));
    idle(4);
    src0[2] = 1'b0;
    idle(5);
    rd(0, 8'h08, v); chk("R7 held choice not re-evaluated", v, 32'h509);
    src0[9] = 1'b1;
    idle(2);
    wr(0, 8'h10, 32'h1);
    idle(4);
    rd(0, 8'h08, v); chk("R7 new choice after ack", v, 32'h002);
    cleanup(0);
  endtask

  task automatic test_edge;
    logic [31:0] v;
    wr(0, 8'h20 + 4*20, cfg(0, 0, 1));
    wr(0, 8'h04, ~(32'h1 << 20));
    @(negedge clk); src0[20] = 1'b0;
    @(negedge clk); src0[20] = 1'b1;
    idle(4);
    chk("R5 edge latched raises irqN", 32'(irqN0), 0);
    rd(0, 8'h00, v); chk("R5 edge pending after release", v[20], 1);
    rd(0, 8'h08, v); chk("R5 source line20", v, 32'h114);
    wr(0, 8'h10, 32'h1);
    idle(2);
    chk("R7 ack releases irqN", 32'(irqN0), 1);
    rd(0, 8'h00, v); chk("R7 ack clears latched edge", v[20], 0);
    // level line not latched
    wr(0, 8'h20 + 4*21, cfg(0, 1, 1));
    src0[21] = 1'b0;
    idle(3);
    rd(0, 8'h00, v); chk("R5 masked level pending visible", v[21], 1);
    src0[21] = 1'b1;
    idle(3);
    rd(0, 8'h00, v); chk("R5 level follows input", v[21], 0);
    // software clear of a latched edge
    wr(0, 8'h04, '1);
    @(negedge clk); src0[20] = 1'b0;
    @(negedge clk); src0[20] = 1'b1;
    idle(3);
    rd(0, 8'h00, v); chk("R5 masked edge latched", v[20], 1);
    wr(0, 8'h00, ~(32'h1 << 20));
    rd(0, 8'h00, v); chk("R6 write 0 clears edge", v[20], 0);
    wr(0, 8'h04, ~(32'h1 << 20));
    idle(4);
    chk("R6 cleared edge not delivered", 32'(irqN0), 1);
    cleanup(0);
  endtask

  task automatic hold_both;
    logic [31:0] v;
    wr(0, 8'h20 + 4*4, cfg(1, 1, 0));
    wr(0, 8'h20 + 4*8, cfg(0, 1, 2));
    src0[4] = 1'b0; src0[8] = 1'b0;
    wr(0, 8'h04, ~((32'h1 << 4) | (32'h1 << 8)));
    idle(4);
    chk("R2 fast line on fiqN", 32'(fiqN0), 0);
    chk("R2 normal line on irqN", 32'(irqN0), 0);
    rd(0, 8'h0C, v); chk("R4 fast source line4", v, 32'h004);
    rd(0, 8'h08, v); chk("R4 normal source line8", v, 32'h208);
    src0[4] = 1'b1; src0[8] = 1'b1;
    idle(2);
  endtask

  task automatic test_fiq;
    hold_both();
    wr(0, 8'h10, 32'h1);
    idle(2);
    chk("R7 bit0 releases irqN", 32'(irqN0), 1);
    chk("R7 bit0 leaves fiqN", 32'(fiqN0), 0);
    wr(0, 8'h10, 32'h2);
    idle(2);
    chk("R7 bit1 releases fiqN", 32'(fiqN0), 1);
    cleanup(0);
  endtask

  task automatic test_ack_both;
    hold_both();
    wr(0, 8'h10, 32'h3);
    idle(2);
    chk("R7 0x3 releases irqN", 32'(irqN0), 1);
    chk("R7 0x3 releases fiqN", 32'(fiqN0), 1);
    cleanup(0);
  endtask

  task automatic test_bank1_fiq;
    logic [31:0] v;
    wr(1, 8'h14, 32'h0);
    wr(1, 8'h20 + 4*3, cfg(1, 1, 1));
    rd(1, 8'h20 + 4*3, v); chk("R3 steering bit forced 0", v, 32'h06);
    src1[3] = 1'b0;
    wr(1, 8'h04, ~(32'h1 << 3));
    idle(4);
    chk("R3 bank1 uses irqN", 32'(irqN1), 0);
    chk("R3 bank1 fiqN quiet", 32'(fiqN1), 1);
    cleanup(1);
  endtask

  task automatic test_cascade;
    logic [31:0] v;
    wr(0, 8'h20, cfg(0, 1, 4));
    wr(1, 8'h20 + 4*6, cfg(0, 1, 0));
    src1[6] = 1'b0;
    wr(1, 8'h04, ~(32'h1 << 6));
    idle(4);
    chk("R9 second bank asserts", 32'(irqN1), 0);
    chk("R9 masked cascade line blocks", 32'(irqN0), 1);
    wr(0, 8'h04, ~32'h1);
    idle(4);
    chk("R9 cascade delivered", 32'(irqN0), 0);
    rd(0, 8'h08, v); chk("R9 source is cascade line", v, 32'h400);
    cleanup(1);
    cleanup(0);
  endtask

  task automatic test_cfg_readback;
    logic [31:0] v;
    wr(0, 8'h20 + 4*31, '1);
    rd(0, 8'h20 + 4*31, v); chk("R2 only low 7 bits kept", v, 32'h7F);
    wr(1, 8'h20 + 4*31, '1);
    rd(1, 8'h20 + 4*31, v); chk("R3 bank1 word drops bit0", v, 32'h7E);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    test_reset();
    test_gate();
    test_mask();
    test_prio();
    test_frozen();
    test_edge();
    test_fiq();
    test_ack_both();
    test_bank1_fiq();
    test_cascade();
    test_cfg_readback();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule